// File: doc/BRIEF.md
# Indirect Table Access Command Engine

This block lets a host reach four small on-chip lookup tables through three registers: two 32-bit data words and one command word. The tables hold VLAN membership, untagged-member masks, per-instance spanning-tree port state and port-isolation masks. To write an entry, the host first loads the data words. It then writes a command word that sets the execute bit, the write direction, a table code and a 12-bit entry index. To read an entry, it writes a command with the direction bit clear, waits for the execute bit to drop, and then reads the data words.

The execute bit does two jobs. It starts an operation and it serves as the busy flag. An accepted operation finishes on the clock edge after the command was taken, and the execute bit then clears. While the execute bit is set, the engine ignores every host write, so an operation in progress cannot be disturbed. The interface is a plain register port (write enable, address, write data, read data). It has no back-pressure: the host is expected to poll the execute bit. The `busy` pin mirrors that bit.

Top module: `itab_engine`

## Requirements
- R1: After reset the command register, both data registers, every table entry and `busy` read as zero.
- R2: A command write (address 0) with bit 17 set, taken while idle, sets bit 17 of the command read-back and `busy`. It holds them for exactly one cycle, then clears them at completion.
- R3: Bit 16 set means write: the data registers are stored into the addressed entry, and the data registers keep their values afterwards.
- R4: Bit 16 clear means read: the entry is copied into the data registers at completion. The data registers change at no other time except on a host data write (address 1 for word 0, address 2 for word 1).
- R5: The table code sits in bits 14:12 of the command: 0 selects VLAN (64 entries), 1 untag (64), 4 spanning-tree (16), 6 isolation (32). Any other code selects no table.
- R6: The index is in bits 11:0. If the index is at or beyond the selected table's depth, or the code selects no table, the operation completes without changing any entry, and a read returns zero in both data words.
- R7: Untag and isolation entries store the port mask from data word 0 bits 31:3. A read returns bits 2:0 as zero and data word 1 as zero.
- R8: A VLAN entry stores all of word 0 and only bits 31:24 of word 1: filter-ID low part, unicast and multicast hash flags, profile. A read returns bits 23:0 of word 1 as zero.
- R9: A spanning-tree entry stores both 32-bit words in full.
- R10: While `busy` is set, host writes to the command and data registers are ignored.
- R11: A command write with bit 17 clear starts nothing: `busy` stays low, and neither the data registers nor any table entry change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select: 0 command, 1 data word 0, 2 data word 1 |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| busy | output | 1 | Operation in progress (same as command bit 17) |

## Verification
The bench goes after indices just past each table's depth. A design that decodes only the low index bits would alias those indices onto entry 0 and corrupt it, or would return stale data where zeros are due. It also sends command and data writes during the busy cycle. A design without the lock would start a second operation or let a host write overwrite the read result. It checks the masked fields (the low three bits of port masks, the low 24 bits of VLAN word 1) and unknown table codes. A wrong field layout would leak stored bits or lose flag bits. Finally, it issues command writes without the execute bit, which must neither raise busy nor touch any table.

// File: rtl/itab_pkg.sv
package itab_pkg;
  localparam int unsigned EXEC_BIT = 17;
  localparam int unsigned DIR_BIT  = 16;
  localparam int unsigned TYPE_LSB = 12;
  localparam int unsigned TYPE_W   = 3;
  localparam int unsigned IDX_W    = 12;
  localparam int unsigned MASK_LSB = 3;
  localparam int unsigned NTABLE   = 4;

  localparam logic [1:0] REG_CMD = 2'd0;
  localparam logic [1:0] REG_D0  = 2'd1;
  localparam logic [1:0] REG_D1  = 2'd2;

  localparam logic [TYPE_W-1:0] CODE_VLAN  = 3'd0;
  localparam logic [TYPE_W-1:0] CODE_UNTAG = 3'd1;
  localparam logic [TYPE_W-1:0] CODE_STP   = 3'd4;
  localparam logic [TYPE_W-1:0] CODE_ISO   = 3'd6;

  // slot numbers of the tables inside the engine
  localparam int unsigned SLOT_VLAN  = 0;
  localparam int unsigned SLOT_UNTAG = 1;
  localparam int unsigned SLOT_STP   = 2;
  localparam int unsigned SLOT_ISO   = 3;

  typedef struct packed {
    logic              wr;
    logic [TYPE_W-1:0] tbl;
    logic [IDX_W-1:0]  idx;
  } cmd_t;
endpackage

// File: rtl/itab_decode.sv
module itab_decode
  import itab_pkg::*;
#(
  parameter int unsigned VLAN_DEPTH  = 64,
  parameter int unsigned UNTAG_DEPTH = 64,
  parameter int unsigned STP_DEPTH   = 16,
  parameter int unsigned ISO_DEPTH   = 32
) (
  input  cmd_t              cmd,
  output logic [NTABLE-1:0] sel,
  output logic              hit
);
  localparam int unsigned DEPTHS [NTABLE] = '{VLAN_DEPTH, UNTAG_DEPTH, STP_DEPTH, ISO_DEPTH};
  localparam logic [TYPE_W-1:0] CODES [NTABLE] = '{CODE_VLAN, CODE_UNTAG, CODE_STP, CODE_ISO};

  for (genvar g = 0; g < NTABLE; g++) begin : g_sel
    assign sel[g] = (cmd.tbl == CODES[g]) && (32'(cmd.idx) < DEPTHS[g]);
  end

  assign hit = |sel;
endmodule

// File: rtl/itab_store.sv
module itab_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/itab_engine.sv
module itab_engine
  import itab_pkg::*;
#(
  parameter int unsigned NPORT       = 29,
  parameter int unsigned VLAN_DEPTH  = 64,
  parameter int unsigned UNTAG_DEPTH = 64,
  parameter int unsigned STP_DEPTH   = 16,
  parameter int unsigned ISO_DEPTH   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        busy
);
  localparam int unsigned VLAN_AW  = (VLAN_DEPTH > 1)  ? $clog2(VLAN_DEPTH)  : 1;
  localparam int unsigned UNTAG_AW = (UNTAG_DEPTH > 1) ? $clog2(UNTAG_DEPTH) : 1;
  localparam int unsigned STP_AW   = (STP_DEPTH > 1)   ? $clog2(STP_DEPTH)   : 1;
  localparam int unsigned ISO_AW   = (ISO_DEPTH > 1)   ? $clog2(ISO_DEPTH)   : 1;
  localparam int unsigned VLAN_HI  = 8;            // kept bits of word 1
  localparam int unsigned VLAN_W   = 32 + VLAN_HI;

  cmd_t        cmd_q;
  logic        busy_q;
  logic [31:0] data0_q, data1_q;
  logic [31:0] rd0, rd1;
  logic [NTABLE-1:0] sel;
  logic        hit;
  logic        accept, start, wr_go;

  logic [VLAN_W-1:0] vlan_rd;
  logic [NPORT-1:0]  untag_rd, iso_rd;
  logic [63:0]       stp_rd;

  logic unused_bits;
  assign unused_bits = ^{host_wdata[31:EXEC_BIT+1], host_wdata[15], data1_q[23:0], hit};

  assign accept = host_we && (host_addr == REG_CMD) && !busy_q;
  assign start  = accept && host_wdata[EXEC_BIT];
  assign wr_go  = busy_q && cmd_q.wr;

  itab_decode #(
    .VLAN_DEPTH(VLAN_DEPTH), .UNTAG_DEPTH(UNTAG_DEPTH),
    .STP_DEPTH(STP_DEPTH), .ISO_DEPTH(ISO_DEPTH)
  ) u_dec (.cmd(cmd_q), .sel(sel), .hit(hit));

  itab_store #(.DEPTH(VLAN_DEPTH), .WIDTH(VLAN_W)) u_vlan (
    .clk(clk), .rst_n(rst_n), .we(wr_go && sel[SLOT_VLAN]),
    .addr(cmd_q.idx[VLAN_AW-1:0]),
    .wdata({data0_q, data1_q[31:32-VLAN_HI]}), .rdata(vlan_rd));

  itab_store #(.DEPTH(UNTAG_DEPTH), .WIDTH(NPORT)) u_untag (
    .clk(clk), .rst_n(rst_n), .we(wr_go && sel[SLOT_UNTAG]),
    .addr(cmd_q.idx[UNTAG_AW-1:0]),
    .wdata(data0_q[MASK_LSB +: NPORT]), .rdata(untag_rd));

  itab_store #(.DEPTH(STP_DEPTH), .WIDTH(64)) u_stp (
    .clk(clk), .rst_n(rst_n), .we(wr_go && sel[SLOT_STP]),
    .addr(cmd_q.idx[STP_AW-1:0]),
    .wdata({data1_q, data0_q}), .rdata(stp_rd));

  itab_store #(.DEPTH(ISO_DEPTH), .WIDTH(NPORT)) u_iso (
    .clk(clk), .rst_n(rst_n), .we(wr_go && sel[SLOT_ISO]),
    .addr(cmd_q.idx[ISO_AW-1:0]),
    .wdata(data0_q[MASK_LSB +: NPORT]), .rdata(iso_rd));

  // unpack the selected entry into data-word layout; zero when no table hit
  always_comb begin
    rd0 = '0;
    rd1 = '0;
    if (sel[SLOT_VLAN]) begin
      rd0 = vlan_rd[VLAN_W-1:VLAN_HI];
      rd1[31:32-VLAN_HI] = vlan_rd[VLAN_HI-1:0];
    end else if (sel[SLOT_UNTAG]) begin
      rd0[MASK_LSB +: NPORT] = untag_rd;
    end else if (sel[SLOT_STP]) begin
      rd0 = stp_rd[31:0];
      rd1 = stp_rd[63:32];
    end else if (sel[SLOT_ISO]) begin
      rd0[MASK_LSB +: NPORT] = iso_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      busy_q  <= 1'b0;
      data0_q <= '0;
      data1_q <= '0;
    end else begin
      busy_q <= start;
      if (accept) begin
        cmd_q.wr  <= host_wdata[DIR_BIT];
        cmd_q.tbl <= host_wdata[TYPE_LSB +: TYPE_W];
        cmd_q.idx <= host_wdata[IDX_W-1:0];
      end
      if (busy_q) begin
        if (!cmd_q.wr) begin
          data0_q <= rd0;
          data1_q <= rd1;
        end
      end else if (host_we && host_addr == REG_D0) begin
        data0_q <= host_wdata;
      end else if (host_we && host_addr == REG_D1) begin
        data1_q <= host_wdata;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      REG_CMD: begin
        host_rdata[EXEC_BIT]              = busy_q;
        host_rdata[DIR_BIT]               = cmd_q.wr;
        host_rdata[TYPE_LSB +: TYPE_W]    = cmd_q.tbl;
        host_rdata[IDX_W-1:0]             = cmd_q.idx;
      end
      REG_D0:  host_rdata = data0_q;
      REG_D1:  host_rdata = data1_q;
      default: host_rdata = '0;
    endcase
  end

  assign busy = busy_q;
endmodule

// File: rtl/itab_checker.sv
module itab_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [1:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic        busy,
  input logic [15:0] cmd_word,
  input logic [31:0] data0,
  input logic [31:0] data1,
  input logic        hit
);
  logic cmd_wr;
  assign cmd_wr = cmd_word[15];

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 2'd0 && host_wdata[17] && !busy) |=> busy); // R2

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R2

  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ($stable(data0) && $stable(data1))); // R3

  AST_DATA_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(host_we && (host_addr == 2'd1 || host_addr == 2'd2)))
      |=> ($stable(data0) && $stable(data1))); // R4

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_wr && !hit) |=> (data0 == 32'd0 && data1 == 32'd0)); // R6

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && host_addr == 2'd0) |=> $stable(cmd_word)); // R10

  AST_NOEXEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 2'd0 && !host_wdata[17] && !busy) |=> !busy); // R11
endmodule

bind itab_engine itab_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .busy(busy_q), .cmd_word(cmd_q),
  .data0(data0_q), .data1(data1_q), .hit(hit)
);

// File: tb/sim_itab_engine.sv
module sim_itab_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit [39:0] mv [64];
  bit [28:0] mu [64];
  bit [63:0] ms [16];
  bit [28:0] mi [32];
  bit [31:0] md0 = 0, md1 = 0;

  always #4 clk = ~clk;   // 125 MHz

  itab_engine u0 (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
                  .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_range(input bit [2:0] t, input int idx);
    case (t)
      3'd0: return idx < 64;
      3'd1: return idx < 64;
      3'd4: return idx < 16;
      3'd6: return idx < 32;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit [63:0] expect_entry(input bit [2:0] t, input int idx);
    bit [63:0] r = 0;
    if (!in_range(t, idx)) return 0;
    case (t)
      3'd0: begin r[31:0] = mv[idx][39:8]; r[63:56] = mv[idx][7:0]; end
      3'd1: r[31:0] = {mu[idx], 3'b000};
      3'd4: r = ms[idx];
      3'd6: r[31:0] = {mi[idx], 3'b000};
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input bit [2:0] t, input int idx);
    if (!in_range(t, idx)) return (t inside {3'd0, 3'd1, 3'd4, 3'd6}) ? "R6" : "R5";
    case (t)
      3'd0: return "R8";
      3'd4: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic set_data(input bit [31:0] d0, input bit [31:0] d1);
    wr_reg(2'd1, d0); md0 = d0;
    wr_reg(2'd2, d1); md1 = d1;
  endtask

  function automatic logic [31:0] mk_cmd(input bit ex, input bit wr, input bit [2:0] t, input int idx);
    return (32'(ex) << 17) | (32'(wr) << 16) | (32'(t) << 12) | (32'(idx) & 32'hfff);
  endfunction

  task automatic model_apply(input bit wr, input bit [2:0] t, input int idx);
    if (wr) begin
      if (in_range(t, idx))
        case (t)
          3'd0: mv[idx] = {md0, md1[31:24]};
          3'd1: mu[idx] = md0[31:3];
          3'd4: ms[idx] = {md1, md0};
          3'd6: mi[idx] = md0[31:3];
          default: ;
        endcase
    end else begin
      {md1, md0} = expect_entry(t, idx);
    end
  endtask

  task automatic run_cmd(input bit wr, input bit [2:0] t, input int idx);
    logic [31:0] v;
    wr_reg(2'd0, mk_cmd(1'b1, wr, t, idx));
    chk("R2 busy after start", 32'(busy), 32'd1);
    @(negedge clk);
    rd_reg(2'd0, v);
    chk("R2 exec cleared", 32'(v[17]), 32'd0);
    model_apply(wr, t, idx);
    rd_reg(2'd1, v);
    chk(wr ? "R3 data0 kept" : {tag_of(t, idx), " R4 data0"}, v, md0);
    rd_reg(2'd2, v);
    chk(wr ? "R3 data1 kept" : {tag_of(t, idx), " R4 data1"}, v, md1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit [2:0] codes [6] = '{3'd0, 3'd1, 3'd4, 3'd6, 3'd2, 3'd7};
    int unsigned seed_sink;
    seed_sink = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 cmd reset", v, 32'd0);
    rd_reg(2'd1, v); chk("R1 data0 reset", v, 32'd0);
    rd_reg(2'd2, v); chk("R1 data1 reset", v, 32'd0);
    chk("R1 busy reset", 32'(busy), 32'd0);
    run_cmd(1'b0, 3'd4, 3);

    // R9 spanning-tree full words
    set_data(32'hA5A5_1234, 32'hFFFF_0001);
    run_cmd(1'b1, 3'd4, 5);
    set_data(0, 0);
    run_cmd(1'b0, 3'd4, 5);

    // R7 mask tables drop low bits
    set_data(32'hFFFF_FFFF, 32'h1234_5678);
    run_cmd(1'b1, 3'd1, 63);
    run_cmd(1'b1, 3'd6, 0);
    run_cmd(1'b0, 3'd1, 63);
    run_cmd(1'b0, 3'd6, 0);

    // R8 VLAN word 1 keeps top byte only
    set_data(32'h8000_0007, 32'hFFFF_FFFF);
    run_cmd(1'b1, 3'd0, 0);
    set_data(0, 0);
    run_cmd(1'b0, 3'd0, 0);

    // R6 out of range: no aliasing, zeros on read
    set_data(32'h1111_1111, 32'h2222_2222);
    run_cmd(1'b1, 3'd0, 64);
    run_cmd(1'b1, 3'd4, 16);
    run_cmd(1'b0, 3'd0, 64);
    run_cmd(1'b0, 3'd0, 0);
    run_cmd(1'b0, 3'd4, 0);
    // R5 unknown table code
    run_cmd(1'b0, 3'd2, 1);

    // R10 command write during busy ignored
    @(negedge clk);
    host_we = 1'b1; host_addr = 2'd0; host_wdata = mk_cmd(1'b1, 1'b0, 3'd4, 5);
    @(negedge clk);
    host_wdata = mk_cmd(1'b1, 1'b1, 3'd0, 1);
    @(negedge clk);
    host_we = 1'b0;
    model_apply(1'b0, 3'd4, 5);
    chk("R10 no second op", 32'(busy), 32'd0);
    rd_reg(2'd0, v); chk("R10 cmd unchanged", v, mk_cmd(1'b0, 1'b0, 3'd4, 5));
    rd_reg(2'd1, v); chk("R10 read result d0", v, md0);
    run_cmd(1'b0, 3'd0, 1);

    // R10 data write during busy ignored
    @(negedge clk);
    host_we = 1'b1; host_addr = 2'd0; host_wdata = mk_cmd(1'b1, 1'b0, 3'd4, 5);
    @(negedge clk);
    host_addr = 2'd1; host_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    host_we = 1'b0;
    model_apply(1'b0, 3'd4, 5);
    rd_reg(2'd1, v); chk("R10 data write ignored", v, md0);

    // R11 command without execute
    set_data(32'h0F0F_0F0F, 32'hF0F0_F0F0);
    wr_reg(2'd0, mk_cmd(1'b0, 1'b1, 3'd4, 5));
    chk("R11 no busy", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R11 still idle", 32'(busy), 32'd0);
    rd_reg(2'd1, v); chk("R11 data0 kept", v, md0);
    run_cmd(1'b0, 3'd4, 5);

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit [2:0] t;
      int idx;
      bit wr;
      t = codes[(n % 9 == 0) ? 4 + $urandom_range(0, 1) : $urandom_range(0, 3)];
      idx = $urandom_range(0, 79);
      wr = $urandom_range(0, 1) == 1;
      if (wr) set_data($urandom, $urandom);
      run_cmd(wr, t, idx);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule